// File: doc/BRIEF.md
# Consecutive-Superframe Maintenance Bit Filter

This block sits behind the deframer of a line transceiver and receives one 8-bit maintenance-channel byte per superframe. Each bit is debounced on its own: the value reported to the host moves only after the received bit has held a new value for two consecutive superframes. Three superframes are required for the activation bit, the deactivation bit and one auxiliary bit when the triple-check control is set. The host reads the filtered byte and a status word through a small register port. A sticky interrupt flag announces any filtered change.

In automatic mode the block also derives verified activation and verified deactivation flags from the same persistence logic. Each flag is OR-ed with a host control bit to drive the customer-transparency and deactivation-response outputs, so the line can react without host involvement. Before the link is up, the host may write a preset into the filtered register. That preset is reloaded each time superframe sync comes back.

Bytes arrive on a valid/ready stream. The block never applies back-pressure: `rx_ready_o` is held high. A byte is taken on a cycle with `rx_valid_i` high only while `sf_sync_i` is high. Bytes offered while sync is low are consumed and discarded.

Top module: `mchan_bit_filter`

## Requirements
- R1: A filtered bit takes the received value only when that value was received in two consecutive accepted bytes; a value present in a single byte never reaches the register (from 0x00, bytes 0x81 then 0x11 leave 0x01).
- R2: Hardware reset (`rst_n` low) or a one-cycle `soft_rst_i` pulse clears the filtered byte, the preset, the interrupt flag and both verified flags to zero.
- R3: A host write to address 0 sets both the filtered byte and the preset only while `link_up_i` or `sf_sync_i` is low; with both high the write is ignored.
- R4: While `sf_sync_i` is low, offered bytes are discarded and the per-bit history is cleared. On every 0-to-1 transition of `sf_sync_i` the preset is copied into the filtered byte.
- R5: The interrupt flag (status bit 0, address 1, also `irq_o`) is set in the cycle a filtered bit changes from an accepted byte. It stays set until the host writes address 1 with bit 0 = 1.
- R6: Status bit 1 is the verified activation flag. In mode 00 it becomes 1 after bit 7 is received as 1 in consecutive bytes, and 0 after bit 7 is received as 0 likewise, in both NT and LT roles.
- R7: Status bit 2 is the verified deactivation flag. In mode 00 with `nt_role_i` high it becomes 1 after bit 6 is received as 0 in consecutive bytes, and 0 after bit 6 is received as 1 likewise. With `nt_role_i` low it stays 0.
- R8: Both verified flags are cleared on every rising edge of `sf_sync_i` and are held at 0 while `mode_i` is not 00; the bit filter itself works the same in all modes.
- R9: With `trinal_en_i` high, bits 7, 6 and 1 need three consecutive equal bytes instead of two, and the verified flags follow those triple-checked values.
- R10: `cust_transp_o` equals verified activation OR `cust_en_i`; `deact_resp_o` equals verified deactivation OR `deact_req_i`.
- R11: `rx_ready_o` is always 1; a byte counts only when `rx_valid_i` and `sf_sync_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous software reset |
| link_up_i | input | 1 | Link established indication |
| sf_sync_i | input | 1 | Superframe sync acquired |
| mode_i | input | 2 | Filter mode; 00 enables verified flags |
| nt_role_i | input | 1 | 1 = network-termination role, 0 = line-termination role |
| trinal_en_i | input | 1 | Triple-superframe check on bits 7, 6, 1 |
| cust_en_i | input | 1 | Host customer-enable control |
| deact_req_i | input | 1 | Host deactivation-request control |
| rx_valid_i | input | 1 | Maintenance byte valid |
| rx_ready_o | output | 1 | Always 1 |
| rx_byte_i | input | 8 | Received maintenance byte |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | Register select: 0 filtered byte, 1 status |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (combinational) |
| irq_o | output | 1 | Sticky change interrupt |
| cust_transp_o | output | 1 | Customer data transparency enable |
| deact_resp_o | output | 1 | Deactivation response enable |

## Verification
The bench uses byte patterns that flip a bit for a single superframe. A filter that commits on first sight would show those glitches in the register and raise the interrupt. With triple checking on, it checks that the second matching byte does not yet move bits 7, 6 or 1; a design that ignored the triple check would change the register and the verified flags one superframe early. It also drops and regains sync around a single byte. A design that kept the per-bit history across the loss would commit from that stale history, and one that skipped the preset reload would keep the old register value. It also covers locked host writes, LT role on the deactivation flag, and the verified flags in a non-automatic mode, where a leaky design would still raise the outputs.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam logic       REG_FILT  = 1'b0;
  localparam logic       REG_STAT  = 1'b1;
  localparam int         ST_IRQ    = 0;
  localparam int         ST_VACT   = 1;
  localparam int         ST_VDEA   = 2;
  localparam logic [1:0] MODE_AUTO = 2'b00;
endpackage

// File: rtl/mcf_persist_cell.sv
module mcf_persist_cell #(
  parameter int RUN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  input  logic need3_i,
  output logic qual_o
);
  localparam logic [RUN_W-1:0] RUN_MAX  = '1;
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);
  localparam logic [RUN_W-1:0] NEED_DUO = RUN_W'(2);
  localparam logic [RUN_W-1:0] NEED_TRI = RUN_W'(3);

  logic             last_q;
  logic [RUN_W-1:0] run_q, run_nx, need;

  always_comb begin
    if (run_q != '0 && last_q == bit_i)
      run_nx = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
    else
      run_nx = RUN_ONE;
  end

  assign need   = need3_i ? NEED_TRI : NEED_DUO;
  assign qual_o = step_i && (run_nx >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      run_q  <= '0;
    end else if (clr_i) begin
      last_q <= 1'b0;
      run_q  <= '0;
    end else if (step_i) begin
      last_q <= bit_i;
      run_q  <= run_nx;
    end
  end
endmodule

// File: rtl/mcf_verify.sv
module mcf_verify import mcf_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst_i,
  input  logic       sync_rise_i,
  input  logic [1:0] mode_i,
  input  logic       nt_role_i,
  input  logic       act_qual_i,
  input  logic       act_bit_i,
  input  logic       dea_qual_i,
  input  logic       dea_bit_i,
  output logic       vact_o,
  output logic       vdea_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vact_o <= 1'b0;
      vdea_o <= 1'b0;
    end else if (soft_rst_i || sync_rise_i || mode_i != MODE_AUTO) begin
      vact_o <= 1'b0;
      vdea_o <= 1'b0;
    end else begin
      if (act_qual_i) vact_o <= act_bit_i;
      if (!nt_role_i)      vdea_o <= 1'b0;
      else if (dea_qual_i) vdea_o <= ~dea_bit_i;
    end
  end
endmodule

// File: rtl/mcf_host_regs.sv
module mcf_host_regs import mcf_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic         sync_rise_i,
  input  logic         unlock_i,
  input  logic         host_wr_i,
  input  logic         host_addr_i,
  input  logic [W-1:0] host_wdata_i,
  input  logic [W-1:0] qual_i,
  input  logic [W-1:0] rx_byte_i,
  input  logic         vact_i,
  input  logic         vdea_i,
  output logic [W-1:0] filt_o,
  output logic         irq_o,
  output logic [W-1:0] host_rdata_o
);
  logic [W-1:0] preset_q, filt_nx, commit_mask, stat;
  logic         wr_filt, clr_irq;

  assign wr_filt     = host_wr_i && host_addr_i == REG_FILT && unlock_i;
  assign clr_irq     = host_wr_i && host_addr_i == REG_STAT && host_wdata_i[ST_IRQ];
  assign commit_mask = qual_i & (rx_byte_i ^ filt_o);
  assign filt_nx     = (filt_o & ~qual_i) | (rx_byte_i & qual_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            preset_q <= '0;
    else if (soft_rst_i)   preset_q <= '0;
    else if (wr_filt)      preset_q <= host_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            filt_o <= '0;
    else if (soft_rst_i)   filt_o <= '0;
    else if (wr_filt)      filt_o <= host_wdata_i;
    else if (sync_rise_i)  filt_o <= preset_q;
    else                   filt_o <= filt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              irq_o <= 1'b0;
    else if (soft_rst_i)     irq_o <= 1'b0;
    else if (|commit_mask)   irq_o <= 1'b1;
    else if (clr_irq)        irq_o <= 1'b0;
  end

  always_comb begin
    stat          = '0;
    stat[ST_IRQ]  = irq_o;
    stat[ST_VACT] = vact_i;
    stat[ST_VDEA] = vdea_i;
    host_rdata_o  = (host_addr_i == REG_STAT) ? stat : filt_o;
  end
endmodule

// File: rtl/mchan_bit_filter.sv
module mchan_bit_filter import mcf_pkg::*; #(
  parameter int W       = 8,
  parameter int ACT_IDX = 7,
  parameter int DEA_IDX = 6,
  parameter int AUX_IDX = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic         link_up_i,
  input  logic         sf_sync_i,
  input  logic [1:0]   mode_i,
  input  logic         nt_role_i,
  input  logic         trinal_en_i,
  input  logic         cust_en_i,
  input  logic         deact_req_i,
  input  logic         rx_valid_i,
  output logic         rx_ready_o,
  input  logic [W-1:0] rx_byte_i,
  input  logic         host_wr_i,
  input  logic         host_addr_i,
  input  logic [W-1:0] host_wdata_i,
  output logic [W-1:0] host_rdata_o,
  output logic         irq_o,
  output logic         cust_transp_o,
  output logic         deact_resp_o
);
  localparam int RUN_W = 2;

  logic         sync_q, sync_rise, accept, hist_clr, unlock;
  logic         irq, vact, vdea;
  logic [W-1:0] qual, need3, filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sync_q <= 1'b0;
    else if (soft_rst_i) sync_q <= 1'b0;
    else                 sync_q <= sf_sync_i;
  end

  assign sync_rise  = sf_sync_i & ~sync_q;
  assign rx_ready_o = 1'b1;
  assign accept     = rx_valid_i & rx_ready_o & sf_sync_i;
  assign hist_clr   = soft_rst_i | ~sf_sync_i;
  assign unlock     = ~link_up_i | ~sf_sync_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    localparam bit IS_TRI = (i == ACT_IDX) || (i == DEA_IDX) || (i == AUX_IDX);
    assign need3[i] = trinal_en_i & IS_TRI;
    mcf_persist_cell #(.RUN_W(RUN_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (hist_clr),
      .step_i  (accept),
      .bit_i   (rx_byte_i[i]),
      .need3_i (need3[i]),
      .qual_o  (qual[i])
    );
  end

  mcf_verify u_verify (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst_i),
    .sync_rise_i (sync_rise),
    .mode_i      (mode_i),
    .nt_role_i   (nt_role_i),
    .act_qual_i  (qual[ACT_IDX]),
    .act_bit_i   (rx_byte_i[ACT_IDX]),
    .dea_qual_i  (qual[DEA_IDX]),
    .dea_bit_i   (rx_byte_i[DEA_IDX]),
    .vact_o      (vact),
    .vdea_o      (vdea)
  );

  mcf_host_regs #(.W(W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .sync_rise_i  (sync_rise),
    .unlock_i     (unlock),
    .host_wr_i    (host_wr_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .qual_i       (qual),
    .rx_byte_i    (rx_byte_i),
    .vact_i       (vact),
    .vdea_i       (vdea),
    .filt_o       (filt),
    .irq_o        (irq),
    .host_rdata_o (host_rdata_o)
  );

  assign irq_o         = irq;
  assign cust_transp_o = vact | cust_en_i;
  assign deact_resp_o  = vdea | deact_req_i;
endmodule

// File: rtl/mchan_bit_filter_chk.sv
module mchan_bit_filter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_rst_i,
  input logic [1:0]   mode_i,
  input logic         nt_role_i,
  input logic         host_wr_i,
  input logic         accept_i,
  input logic         sync_rise_i,
  input logic [W-1:0] filt_i,
  input logic         irq_i,
  input logic         vact_i,
  input logic         vdea_i
);
  // R1: the filtered byte moves only on an accepted byte, a reload, a host write or a reset
  p_filt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(accept_i) && !$past(sync_rise_i) && !$past(host_wr_i) && !$past(soft_rst_i))
      |-> $stable(filt_i));

  // R5: the interrupt can only rise after an accepted byte
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_i) |-> $past(accept_i));

  // R2: software reset clears the visible state
  p_soft_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst_i) |-> (filt_i == '0 && !irq_i && !vact_i && !vdea_i));

  // R8: verified flags held at zero outside mode 00
  p_vflags_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i != 2'b00) |-> (!vact_i && !vdea_i));

  // R8: verified flags cleared by a sync rising edge
  p_rise_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_rise_i) |-> (!vact_i && !vdea_i));

  // R7: deactivation flag stays low in the LT role
  p_lt_dea_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!nt_role_i) |-> !vdea_i);
endmodule

bind mchan_bit_filter mchan_bit_filter_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst_i  (soft_rst_i),
  .mode_i      (mode_i),
  .nt_role_i   (nt_role_i),
  .host_wr_i   (host_wr_i),
  .accept_i    (accept),
  .sync_rise_i (sync_rise),
  .filt_i      (filt),
  .irq_i       (irq),
  .vact_i      (vact),
  .vdea_i      (vdea)
);

// File: tb/mchan_bit_filter_tb_top.sv
`timescale 1ns/1ps
module mchan_bit_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, link_up = 1'b1, sf_sync = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       nt_role = 1'b1, trinal = 1'b0, cust_en = 1'b0, deact_req = 1'b0;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_byte = 8'h00;
  logic       host_wr = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00, host_rdata;
  logic       irq, cust, deact;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] f;
    logic       i, a, d;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  mchan_bit_filter dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .link_up_i(link_up),
    .sf_sync_i(sf_sync), .mode_i(mode), .nt_role_i(nt_role), .trinal_en_i(trinal),
    .cust_en_i(cust_en), .deact_req_i(deact_req), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .rx_byte_i(rx_byte), .host_wr_i(host_wr),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .irq_o(irq), .cust_transp_o(cust), .deact_resp_o(deact)
  );

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        host_addr = 1'b0;
        #0.2;
        chk(e.tag, "filtered", host_rdata, e.f);
        host_addr = 1'b1;
        #0.2;
        chk(e.tag, "status", host_rdata, {5'b0, e.d, e.a, e.i});
        chk(e.tag, "irq_o/R5", {7'b0, irq}, {7'b0, e.i});
        chk(e.tag, "cust/R10", {6'b0, cust, deact}, {6'b0, e.a | cust_en, e.d | deact_req});
        chk(e.tag, "ready/R11", {7'b0, rx_ready}, 8'h01);
        host_addr = 1'b0;
      end
    end
  end

  task automatic expect_st(string tag, logic [7:0] f, logic i, logic a, logic d);
    exp_t e;
    e.tag = tag; e.f = f; e.i = i; e.a = a; e.d = d;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic host_write(logic a, logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0; host_addr = 1'b0;
  endtask

  task automatic w1c();
    host_write(1'b1, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    expect_st("R2 reset state", 8'h00, 0, 0, 0);

    // R1 / R7: first byte never commits, second equal byte does
    send(8'h00);
    expect_st("R1 single byte", 8'h00, 0, 0, 0);
    send(8'h00);
    expect_st("R7 dea 0 twice NT", 8'h00, 0, 0, 1);
    send(8'h81);
    expect_st("R1 glitch 81 ignored", 8'h00, 0, 0, 1);
    send(8'h11);
    expect_st("R1 81 then 11 gives 01", 8'h01, 1, 0, 1);
    w1c();
    expect_st("R5 write-one-to-clear", 8'h01, 0, 0, 1);

    // R6 / R7: act and dea change through two equal bytes
    send(8'hC1);
    expect_st("R6 one C1 no change", 8'h01, 0, 0, 1);
    send(8'hC1);
    expect_st("R6 act 1 twice", 8'hC1, 1, 1, 0);
    deact_req = 1'b1;
    expect_st("R10 deact request OR", 8'hC1, 1, 1, 0);
    deact_req = 1'b0;
    host_write(1'b0, 8'hFF);
    expect_st("R3 locked write ignored", 8'hC1, 1, 1, 0);
    w1c();

    // R9: triple check on bits 7, 6, 1
    trinal = 1'b1;
    send(8'h01);
    send(8'h01);
    expect_st("R9 two bytes not enough", 8'hC1, 0, 1, 0);
    send(8'h01);
    expect_st("R9 third byte commits", 8'h01, 1, 0, 1);
    w1c();
    send(8'h03);
    send(8'h03);
    expect_st("R9 aux bit1 waits", 8'h01, 0, 0, 1);
    send(8'h03);
    expect_st("R9 aux bit1 commits", 8'h03, 1, 0, 1);
    trinal = 1'b0;
    w1c();

    // R4 / R3 / R8: sync loss, preset, reload
    sf_sync = 1'b0;
    tick();
    send(8'hF0);
    send(8'hF0);
    expect_st("R4 bytes ignored w/o sync", 8'h03, 0, 0, 1);
    host_write(1'b0, 8'h5A);
    expect_st("R3 unlocked write", 8'h5A, 0, 0, 1);
    sf_sync = 1'b1;
    tick();
    expect_st("R8 rise clears flags", 8'h5A, 0, 0, 0);
    send(8'h00);
    send(8'h00);
    expect_st("R1 commit after resync", 8'h00, 1, 0, 1);
    w1c();
    sf_sync = 1'b0;
    tick(); tick();
    sf_sync = 1'b1;
    tick();
    expect_st("R4 preset reload on rise", 8'h5A, 0, 0, 0);
    send(8'hFF);
    sf_sync = 1'b0;
    tick();
    sf_sync = 1'b1;
    tick();
    send(8'hFF);
    expect_st("R4 history cleared on loss", 8'h5A, 0, 0, 0);
    link_up = 1'b0;
    host_write(1'b0, 8'h3C);
    link_up = 1'b1;
    expect_st("R3 write with link down", 8'h3C, 0, 0, 0);

    // R8: other mode keeps flags low; filter still runs
    mode = 2'b01;
    cust_en = 1'b1;
    send(8'h80);
    send(8'h80);
    expect_st("R8 mode 01 no flags", 8'h80, 1, 0, 0);

    // R7 / R6 in LT role
    mode = 2'b00;
    cust_en = 1'b0;
    nt_role = 1'b0;
    w1c();
    send(8'h00);
    send(8'h00);
    expect_st("R7 LT dea stays 0", 8'h00, 1, 0, 0);
    send(8'h80);
    send(8'h80);
    expect_st("R6 LT act works", 8'h80, 1, 1, 0);

    // R2: software reset
    @(posedge clk); #1 soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
    tick();
    expect_st("R2 soft reset", 8'h00, 0, 0, 0);

    repeat (4) tick();
    finish_run();
  end
endmodule